// File: doc/BRIEF.md
# Way-Partitioned Victim Way Selector

This block chooses which way of a set-associative cache set receives a new line after a miss. The cache controller presents the tag state of the addressed set: a valid, dirty, lock and use bit for every way. It also presents a fill strobe and the identity of the requester. One clock later the block returns the chosen way and a writeback flag. When nothing may be evicted it returns a no-victim pulse instead, and the requester then does not allocate.

Every requester owns a partition mask. A bit set to 1 forbids that requester from evicting the matching way, and a bit at 0 allows it. The masks only restrict replacement. Hits and reads are not the business of this block, so every way remains readable by everyone.

The requesters are numbered as follows:
- 0 to NUM_CORES-1 are the processor cores.
- NUM_CORES is the first hardware-agent group.
- NUM_CORES+1 is the second hardware-agent group.

A small register file holds the masks. It has a write port and a combinational read port. A write that would leave a requester with no evictable way is refused.

Top module: `victim_way_picker`

## Requirements
- R1: After reset every partition mask reads as zero, and victimValid, noVictim, victimDirty and useClearMask are all low.
- R2: A mask write with a requester ID below NUM_CORES+2 and data other than all ones is stored. maskRdData shows the stored mask of maskRdId in the same cycle. Reading an ID of NUM_CORES+2 or above returns all ones.
- R3: A mask write whose data is all ones is refused, and the requester keeps its previous mask. A write to an ID of NUM_CORES+2 or above is also refused.
- R4: A fill only chooses a way whose mask bit is 0 for that requester and whose lock bit is 0. These are the candidates. A fill from an ID outside the requester range has no candidates.
- R5: If any candidate is invalid, the lowest-numbered invalid candidate is chosen.
- R6: Otherwise, the lowest-numbered candidate whose use bit is 0 is chosen.
- R7: If every candidate has its use bit set, the lowest candidate is chosen. In the same cycle, useClearMask shows exactly the candidate set, so the controller can clear those use bits.
- R8: The outputs for a fill sampled at a clock edge appear after that edge and last one cycle. victimValid is high when a candidate exists. noVictim is high when no candidate exists. The two are never high together.
- R9: victimDirty is high together with victimValid exactly when the chosen way is both valid and dirty.
- R10: A write to one requester's mask leaves every other requester's mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| maskWrEn | input | 1 | Mask write strobe |
| maskWrId | input | REQ_W | Requester whose mask is written |
| maskWrData | input | NUM_WAYS | New mask (1 = eviction forbidden) |
| maskRdId | input | REQ_W | Requester whose mask is read |
| maskRdData | output | NUM_WAYS | Stored mask of maskRdId |
| fillReq | input | 1 | Victim selection request |
| fillReqId | input | REQ_W | Requester asking for the fill |
| setValid | input | NUM_WAYS | Valid bit of each way in the set |
| setDirty | input | NUM_WAYS | Dirty bit of each way |
| setLocked | input | NUM_WAYS | Lock bit of each way |
| setUse | input | NUM_WAYS | Use bit of each way |
| victimValid | output | 1 | A victim was chosen |
| victimWay | output | WAY_W | Chosen way |
| victimDirty | output | 1 | Chosen way needs writeback |
| noVictim | output | 1 | No evictable way for this request |
| useClearMask | output | NUM_WAYS | Use bits to clear after a saturated choice |

## Verification
The assertions check several properties on every cycle:
- A chosen way was neither locked nor forbidden for the requester.
- No stored mask is ever all ones.
- The writeback flag and the use-clear mask only appear with a chosen victim.
- A no-victim pulse only follows a fill request.

Other behaviour can only be shown by the bench's directed scenarios. These cover the priority among invalid, not-recently-used and saturated candidates, the exact way number returned, the refusal of bad mask writes seen through read-back, and the independence of requesters' masks.

// File: rtl/vwp_pkg.sv
package vwp_pkg;
  // strobes passed from control to datapath
  typedef struct packed {
    logic maskWrite;
    logic fillTake;
  } vwp_strobe_t;
endpackage

// File: rtl/vwp_ctrl.sv
module vwp_ctrl
  import vwp_pkg::*;
#(
  parameter int NUM_WAYS = 8,
  parameter int NUM_REQ  = 6,
  parameter int REQ_W    = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                maskWrEn,
  input  logic [REQ_W-1:0]    maskWrId,
  input  logic [NUM_WAYS-1:0] maskWrData,
  input  logic                fillReq,
  output vwp_strobe_t         strobe
);
  logic idInRange;
  logic leavesAWay;

  assign idInRange  = int'(maskWrId) < NUM_REQ;
  assign leavesAWay = ~&maskWrData;

  always_comb begin
    strobe           = '0;
    strobe.maskWrite = maskWrEn && idInRange && leavesAWay;
    strobe.fillTake  = fillReq;
  end

  // R3: a refused write never reaches the datapath
  p_refuse_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.maskWrite |-> (maskWrEn && (maskWrData != '1)));
endmodule

// File: rtl/vwp_datapath.sv
module vwp_datapath
  import vwp_pkg::*;
#(
  parameter int NUM_WAYS = 8,
  parameter int NUM_REQ  = 6,
  parameter int REQ_W    = 3,
  parameter int WAY_W    = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  vwp_strobe_t         strobe,
  input  logic [REQ_W-1:0]    maskWrId,
  input  logic [NUM_WAYS-1:0] maskWrData,
  input  logic [REQ_W-1:0]    maskRdId,
  output logic [NUM_WAYS-1:0] maskRdData,
  input  logic [REQ_W-1:0]    fillReqId,
  input  logic                fillReq,
  input  logic [NUM_WAYS-1:0] setValid,
  input  logic [NUM_WAYS-1:0] setDirty,
  input  logic [NUM_WAYS-1:0] setLocked,
  input  logic [NUM_WAYS-1:0] setUse,
  output logic                victimValid,
  output logic [WAY_W-1:0]    victimWay,
  output logic                victimDirty,
  output logic                noVictim,
  output logic [NUM_WAYS-1:0] useClearMask
);
  logic [NUM_WAYS-1:0] maskMem [NUM_REQ];
  logic [NUM_WAYS-1:0] reqMask, cand, invalCand, freshCand, clearNext;
  logic [WAY_W-1:0]    pickWay;

  function automatic logic [WAY_W-1:0] lowestIdx(input logic [NUM_WAYS-1:0] v);
    lowestIdx = '0;
    for (int i = NUM_WAYS - 1; i >= 0; i--)
      if (v[i]) lowestIdx = WAY_W'(i);
  endfunction

  // partition mask register file
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < NUM_REQ; r++) maskMem[r] <= '0;
    end else if (strobe.maskWrite) begin
      maskMem[maskWrId] <= maskWrData;
    end
  end

  assign maskRdData = (int'(maskRdId) < NUM_REQ) ? maskMem[maskRdId] : '1;
  assign reqMask    = (int'(fillReqId) < NUM_REQ) ? maskMem[fillReqId] : '1;

  // candidate selection: invalid first, then use clear, then saturated
  assign cand      = ~reqMask & ~setLocked;
  assign invalCand = cand & ~setValid;
  assign freshCand = cand & ~setUse;

  always_comb begin
    clearNext = '0;
    if (|invalCand)      pickWay = lowestIdx(invalCand);
    else if (|freshCand) pickWay = lowestIdx(freshCand);
    else begin
      pickWay   = lowestIdx(cand);
      clearNext = cand;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      victimValid  <= 1'b0;
      victimWay    <= '0;
      victimDirty  <= 1'b0;
      noVictim     <= 1'b0;
      useClearMask <= '0;
    end else if (strobe.fillTake) begin
      victimValid  <= |cand;
      noVictim     <= ~|cand;
      victimWay    <= pickWay;
      victimDirty  <= (|cand) && setValid[pickWay] && setDirty[pickWay];
      useClearMask <= clearNext;
    end else begin
      victimValid  <= 1'b0;
      noVictim     <= 1'b0;
      victimDirty  <= 1'b0;
      useClearMask <= '0;
    end
  end

  // copies of the request context, for the assertions only
  logic [NUM_WAYS-1:0] lockSeen, maskSeen;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockSeen <= '0;
      maskSeen <= '0;
    end else begin
      lockSeen <= setLocked;
      maskSeen <= reqMask;
    end
  end

  p_unlocked_r4: assert property (@(posedge clk) disable iff (!rstN)
    victimValid |-> !lockSeen[victimWay]);
  p_allowed_r4: assert property (@(posedge clk) disable iff (!rstN)
    victimValid |-> !maskSeen[victimWay]);
  p_exclusive_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(victimValid && noVictim));
  p_novictim_cause_r8: assert property (@(posedge clk) disable iff (!rstN)
    noVictim |-> $past(fillReq));
  p_dirty_needs_victim_r9: assert property (@(posedge clk) disable iff (!rstN)
    victimDirty |-> victimValid);
  p_clear_needs_victim_r7: assert property (@(posedge clk) disable iff (!rstN)
    (|useClearMask) |-> (victimValid && useClearMask[victimWay]));

  for (genvar g = 0; g < NUM_REQ; g++) begin : g_maskChk
    p_mask_keeps_way_r3: assert property (@(posedge clk) disable iff (!rstN)
      maskMem[g] != '1);
  end
endmodule

// File: rtl/victim_way_picker.sv
module victim_way_picker
  import vwp_pkg::*;
#(
  parameter int NUM_WAYS  = 8,
  parameter int NUM_CORES = 4,
  localparam int NUM_REQ  = NUM_CORES + 2,
  localparam int REQ_W    = $clog2(NUM_REQ + 1),
  localparam int WAY_W    = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                maskWrEn,
  input  logic [REQ_W-1:0]    maskWrId,
  input  logic [NUM_WAYS-1:0] maskWrData,
  input  logic [REQ_W-1:0]    maskRdId,
  output logic [NUM_WAYS-1:0] maskRdData,
  input  logic                fillReq,
  input  logic [REQ_W-1:0]    fillReqId,
  input  logic [NUM_WAYS-1:0] setValid,
  input  logic [NUM_WAYS-1:0] setDirty,
  input  logic [NUM_WAYS-1:0] setLocked,
  input  logic [NUM_WAYS-1:0] setUse,
  output logic                victimValid,
  output logic [WAY_W-1:0]    victimWay,
  output logic                victimDirty,
  output logic                noVictim,
  output logic [NUM_WAYS-1:0] useClearMask
);
  vwp_strobe_t strobe;

  vwp_ctrl #(.NUM_WAYS(NUM_WAYS), .NUM_REQ(NUM_REQ), .REQ_W(REQ_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .maskWrEn(maskWrEn), .maskWrId(maskWrId),
    .maskWrData(maskWrData), .fillReq(fillReq), .strobe(strobe)
  );

  vwp_datapath #(.NUM_WAYS(NUM_WAYS), .NUM_REQ(NUM_REQ), .REQ_W(REQ_W),
                 .WAY_W(WAY_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .maskWrId(maskWrId),
    .maskWrData(maskWrData), .maskRdId(maskRdId), .maskRdData(maskRdData),
    .fillReqId(fillReqId), .fillReq(fillReq), .setValid(setValid),
    .setDirty(setDirty), .setLocked(setLocked), .setUse(setUse),
    .victimValid(victimValid), .victimWay(victimWay),
    .victimDirty(victimDirty), .noVictim(noVictim),
    .useClearMask(useClearMask)
  );
endmodule

// File: tb/sim_victim_way_picker.sv
module sim_victim_way_picker;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       maskWrEn = 1'b0;
  logic [2:0] maskWrId = '0;
  logic [7:0] maskWrData = '0;
  logic [2:0] maskRdId = '0;
  logic [7:0] maskRdData;
  logic       fillReq = 1'b0;
  logic [2:0] fillReqId = '0;
  logic [7:0] setValid = '0, setDirty = '0, setLocked = '0, setUse = '0;
  logic       victimValid, victimDirty, noVictim;
  logic [2:0] victimWay;
  logic [7:0] useClearMask;
  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  victim_way_picker #(.NUM_WAYS(8), .NUM_CORES(4)) u0 (
    .clk(clk), .rstN(rstN), .maskWrEn(maskWrEn), .maskWrId(maskWrId),
    .maskWrData(maskWrData), .maskRdId(maskRdId), .maskRdData(maskRdData),
    .fillReq(fillReq), .fillReqId(fillReqId), .setValid(setValid),
    .setDirty(setDirty), .setLocked(setLocked), .setUse(setUse),
    .victimValid(victimValid), .victimWay(victimWay),
    .victimDirty(victimDirty), .noVictim(noVictim),
    .useClearMask(useClearMask)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic writeMask(input logic [2:0] id, input logic [7:0] data);
    @(negedge clk);
    maskWrEn = 1'b1; maskWrId = id; maskWrData = data;
    @(negedge clk);
    maskWrEn = 1'b0;
  endtask

  task automatic readMask(input string tag, input logic [2:0] id, input logic [7:0] exp);
    maskRdId = id;
    #1;
    chk(tag, {24'd0, maskRdData}, {24'd0, exp});
  endtask

  // issue one fill; return after the result has registered
  task automatic fill(input logic [2:0] id, input logic [7:0] v, input logic [7:0] d,
                      input logic [7:0] l, input logic [7:0] u);
    @(negedge clk);
    fillReq = 1'b1; fillReqId = id;
    setValid = v; setDirty = d; setLocked = l; setUse = u;
    @(negedge clk);
    fillReq = 1'b0;
  endtask

  task automatic expectPick(input string tag, input logic [2:0] way, input logic dirty,
                            input logic [7:0] clr);
    chk({tag, " valid"}, {31'd0, victimValid}, 32'd1);
    chk({tag, " noVictim"}, {31'd0, noVictim}, 32'd0);
    chk({tag, " way"}, {29'd0, victimWay}, {29'd0, way});
    chk({tag, " dirty R9"}, {31'd0, victimDirty}, {31'd0, dirty});
    chk({tag, " useClear R7"}, {24'd0, useClearMask}, {24'd0, clr});
  endtask

  task automatic testReset();
    for (int i = 0; i < 6; i++) readMask("R1 mask after reset", 3'(i), 8'h00);
    chk("R1 victimValid", {31'd0, victimValid}, 32'd0);
    chk("R1 noVictim", {31'd0, noVictim}, 32'd0);
    chk("R1 victimDirty", {31'd0, victimDirty}, 32'd0);
    chk("R1 useClearMask", {24'd0, useClearMask}, 32'd0);
  endtask

  task automatic testMaskWrites();
    writeMask(3'd1, 8'h0F);
    readMask("R2 core1 mask", 3'd1, 8'h0F);
    writeMask(3'd4, 8'hF0);
    readMask("R2 group A mask", 3'd4, 8'hF0);
    readMask("R2 read out of range", 3'd7, 8'hFF);
    writeMask(3'd1, 8'hFF);
    readMask("R3 all-ones refused", 3'd1, 8'h0F);
    writeMask(3'd6, 8'h01);
    readMask("R3 out of range id", 3'd6, 8'hFF);
    readMask("R10 core0 untouched", 3'd0, 8'h00);
    readMask("R10 group B untouched", 3'd5, 8'h00);
  endtask

  task automatic testInvalidFirst();
    // core1 may evict ways 4..7 only; ways 1 and 6 invalid; way 6 dirty bit ignored
    fill(3'd1, 8'hBD, 8'h40, 8'h00, 8'h00);
    expectPick("R5 lowest allowed invalid", 3'd6, 1'b0, 8'h00);
    @(negedge clk);
    chk("R8 one-cycle victimValid", {31'd0, victimValid}, 32'd0);
  endtask

  task automatic testUseClear();
    fill(3'd0, 8'hFF, 8'h04, 8'h03, 8'h01);
    expectPick("R4 locked ways skipped", 3'd2, 1'b1, 8'h00);
    fill(3'd0, 8'hFF, 8'h00, 8'h00, 8'h0B);
    expectPick("R6 lowest use-clear", 3'd2, 1'b0, 8'h00);
  endtask

  task automatic testSaturated();
    // group A may evict ways 0..3; way 0 locked
    fill(3'd4, 8'hFF, 8'h02, 8'h01, 8'hFF);
    expectPick("R7 saturated pick", 3'd1, 1'b1, 8'h0E);
  endtask

  task automatic testNoVictim();
    fill(3'd1, 8'hFF, 8'hFF, 8'hF0, 8'h00);
    chk("R8 noVictim when all allowed locked", {31'd0, noVictim}, 32'd1);
    chk("R8 no victimValid", {31'd0, victimValid}, 32'd0);
    chk("R9 no dirty without victim", {31'd0, victimDirty}, 32'd0);
    @(negedge clk);
    chk("R8 noVictim one cycle", {31'd0, noVictim}, 32'd0);
    fill(3'd7, 8'h00, 8'h00, 8'h00, 8'h00);
    chk("R4 out-of-range requester", {31'd0, noVictim}, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testMaskWrites();
    testInvalidFirst();
    testUseClear();
    testSaturated();
    testNoVictim();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule